// File: doc/BRIEF.md
# Byte Field Rotate-Mask-Operate-Insert Path

This block is the data-processing path of a small 8-bit controller. In a single instruction cycle it takes one source byte and rotates it right end-around. When the byte comes from an I/O port, it keeps only a low field of chosen length and forces the other bits to zero. It then combines the operand with an accumulator byte in a four-function ALU. Finally it moves the ALU result left to a chosen bit position and inserts it into a destination byte, so that only the bits of that field change.

The bits outside the field come from a background byte held in the I/O latch. What the latch holds depends on where the data comes from and where it goes:
- register source, I/O destination: the latch holds the destination's current contents.
- I/O source and I/O destination on the same bank: the latch holds the raw source byte.
- I/O source and I/O destination on opposite banks, or a register destination: the whole byte is written and nothing is merged.

A carry register records the carry out of every addition. Instruction decoding and the register file live outside the block. The result and the carry flag are registered, so they appear one clock after the request.

Top module: `field_xfer_path`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `result_o` is 0x00, `ovf_o` is 0 and `res_valid_o` is 0.
- R2: A request with `valid_i` high on a rising edge sets `res_valid_o` high and presents its result on `result_o` after that same edge. Requests may arrive on back-to-back cycles.
- R3: The source byte is rotated right end-around by `rot_i` positions (0 to 7) before any other step.
- R4: With `src_io_i`=1 the rotated byte keeps only bits 0..`len_i`, so the field length is `len_i`+1 and the other bits become 0. With `src_io_i`=0 all 8 bits pass and `len_i` has no effect on the operand.
- R5: `op_i` chooses the ALU function: 00 passes the operand, 01 adds `acc_i` modulo 256, 10 is bitwise AND with `acc_i`, 11 is bitwise XOR with `acc_i`.
- R6: On an addition `ovf_o` takes the carry out of bit 7. It holds its value on the other operations and on idle cycles.
- R7: With `dst_io_i`=1 and `src_io_i`=0, the result is `dst_i` with only the bits `pos_i`..`pos_i`+`len_i` replaced by the ALU result shifted left by `pos_i`.
- R8: With `dst_io_i`=1, `src_io_i`=1 and `same_bank_i`=1, the background of the merge is the unrotated `src_i`. The same byte is also the ALU operand.
- R9: With `dst_io_i`=0, or with I/O source and destination on opposite banks (`same_bank_i`=0), the result is the ALU result shifted left by `pos_i` with zero fill, and no background bit survives.
- R10: Field bits that would fall above bit 7 are dropped. The background keeps every bit the clipped field does not cover.
- R11: On a cycle with `valid_i` low, `res_valid_o` goes low and `result_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 8 | Source byte |
| rot_i | input | 3 | Right-rotate amount |
| len_i | input | 3 | Field length minus one |
| pos_i | input | 3 | Destination bit position of the field's LSB |
| op_i | input | 2 | ALU function code |
| acc_i | input | 8 | Accumulator operand |
| dst_i | input | 8 | Current contents of the destination port |
| src_io_i | input | 1 | Source is an I/O port |
| dst_io_i | input | 1 | Destination is an I/O port |
| same_bank_i | input | 1 | Source and destination share a bank |
| result_o | output | 8 | Processed destination byte |
| res_valid_o | output | 1 | Result strobe |
| ovf_o | output | 1 | Carry register |

## Verification
A wrong background choice or a wrong field mask shows up on `result_o` one clock after the request, as changed bits outside the field or stale bits inside it. A corrupted carry register is harder to see. Its wrong value stays on `ovf_o` until the next addition, so the checks compare `ovf_o` after every request, including the non-add ones that must leave it unchanged. A bad rotate or mask shows only when the operand's bits are not symmetric, so the stimulus uses asymmetric bytes, a range of rotate amounts, and fields that straddle bit 7.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
    typedef enum logic [1:0] {
        OP_MOVE = 2'b00,
        OP_ADD  = 2'b01,
        OP_AND  = 2'b10,
        OP_XOR  = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        BG_NONE = 2'b00,
        BG_DEST = 2'b01,
        BG_SRC  = 2'b10
    } bg_sel_e;
endpackage

// File: rtl/fxp_rotmask.sv
module fxp_rotmask #(
    parameter int W  = 8,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [LW-1:0] rot,
    input  logic [LW-1:0] len,
    input  logic          mask_en,
    output logic [W-1:0]  operand
);
    localparam logic [W-1:0]  ONES = '1;
    localparam logic [LW-1:0] TOP  = LW'(W - 1);

    logic [2*W-1:0] doubled;
    logic [2*W-1:0] spun;
    logic [W-1:0]   fieldmask;

    always_comb begin
        doubled   = {src, src};
        spun      = doubled >> rot;
        fieldmask = ONES >> (TOP - len);
        operand   = mask_en ? (spun[W-1:0] & fieldmask) : spun[W-1:0];
    end
endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
    import fxp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         carry
);
    logic [W:0] sum;

    always_comb begin
        sum   = {1'b0, a} + {1'b0, b};
        carry = 1'b0;
        unique case (op)
            OP_MOVE: y = a;
            OP_ADD: begin
                y     = sum[W-1:0];
                carry = sum[W];
            end
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/fxp_merge.sv
module fxp_merge
    import fxp_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  alu_y,
    input  logic [LW-1:0] pos,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  background,
    input  bg_sel_e       sel,
    output logic [W-1:0]  merged
);
    localparam logic [W-1:0]  ONES = '1;
    localparam logic [LW-1:0] TOP  = LW'(W - 1);

    logic [W-1:0] placed;
    logic [W-1:0] window;

    always_comb begin
        placed = alu_y << pos;
        window = (ONES >> (TOP - len)) << pos;
        unique case (sel)
            BG_DEST, BG_SRC: merged = (background & ~window) | (placed & window);
            default:         merged = placed;
        endcase
    end
endmodule

// File: rtl/field_xfer_path.sv
module field_xfer_path
    import fxp_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [W-1:0]  src_i,
    input  logic [LW-1:0] rot_i,
    input  logic [LW-1:0] len_i,
    input  logic [LW-1:0] pos_i,
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  dst_i,
    input  logic          src_io_i,
    input  logic          dst_io_i,
    input  logic          same_bank_i,
    output logic [W-1:0]  result_o,
    output logic          res_valid_o,
    output logic          ovf_o
);
    logic [W-1:0] operand;
    logic [W-1:0] alu_y;
    logic         alu_carry;
    logic [W-1:0] latch_bg;
    logic [W-1:0] merged;
    bg_sel_e      bg_sel;
    alu_op_e      op_sel;

    assign op_sel = alu_op_e'(op_i);

    // Choice of what the I/O latch holds for this request
    always_comb begin
        unique case ({dst_io_i, src_io_i})
            2'b10:   bg_sel = BG_DEST;
            2'b11:   bg_sel = same_bank_i ? BG_SRC : BG_NONE;
            default: bg_sel = BG_NONE;
        endcase
        unique case (bg_sel)
            BG_DEST: latch_bg = dst_i;
            BG_SRC:  latch_bg = src_i;
            default: latch_bg = '0;
        endcase
    end

    fxp_rotmask #(.W(W), .LW(LW)) u_rotmask (
        .src     (src_i),
        .rot     (rot_i),
        .len     (len_i),
        .mask_en (src_io_i),
        .operand (operand)
    );

    fxp_alu #(.W(W)) u_alu (
        .a     (operand),
        .b     (acc_i),
        .op    (op_sel),
        .y     (alu_y),
        .carry (alu_carry)
    );

    fxp_merge #(.W(W), .LW(LW)) u_merge (
        .alu_y      (alu_y),
        .pos        (pos_i),
        .len        (len_i),
        .background (latch_bg),
        .sel        (bg_sel),
        .merged     (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o    <= '0;
            res_valid_o <= 1'b0;
            ovf_o       <= 1'b0;
        end else begin
            res_valid_o <= valid_i;
            if (valid_i) begin
                result_o <= merged;
                if (op_sel == OP_ADD) begin
                    ovf_o <= alu_carry;
                end
            end
        end
    end
endmodule

// File: rtl/fxp_checker.sv
module fxp_checker
    import fxp_pkg::*;
#(
    parameter int W  = 8,
    parameter int LW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [W-1:0]  dst_i,
    input logic [LW-1:0] len_i,
    input logic [LW-1:0] pos_i,
    input logic [1:0]    op_i,
    input logic [W-1:0]  acc_i,
    input logic          src_io_i,
    input logic          dst_io_i,
    input logic          same_bank_i,
    input logic [W-1:0]  result_o,
    input logic          res_valid_o,
    input logic          ovf_o
);
    logic [W-1:0] span;

    always_comb begin
        span = '0;
        for (int i = 0; i < W; i++) begin
            if (i >= int'(pos_i) && i <= int'(pos_i) + int'(len_i)) begin
                span[i] = 1'b1;
            end
        end
    end

    p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_valid_o && $stable(result_o)));

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i != 2'b01) |=> $stable(ovf_o));

    p_ovf_zero_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b01 && acc_i == '0) |=> !ovf_o);

    p_keep_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dst_io_i && !src_io_i)
        |=> (((result_o ^ $past(dst_i)) & ~$past(span)) == '0));

    p_full_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b10 && acc_i == '0 &&
         (!dst_io_i || (src_io_i && !same_bank_i)))
        |=> (result_o == '0));
endmodule

bind field_xfer_path fxp_checker #(.W(W), .LW(LW)) u_fxp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .dst_i       (dst_i),
    .len_i       (len_i),
    .pos_i       (pos_i),
    .op_i        (op_i),
    .acc_i       (acc_i),
    .src_io_i    (src_io_i),
    .dst_io_i    (dst_io_i),
    .same_bank_i (same_bank_i),
    .result_o    (result_o),
    .res_valid_o (res_valid_o),
    .ovf_o       (ovf_o)
);

// File: tb/field_xfer_path_test.sv
module field_xfer_path_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] src_i = '0;
    logic [2:0] rot_i = '0;
    logic [2:0] len_i = '0;
    logic [2:0] pos_i = '0;
    logic [1:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] dst_i = '0;
    logic       src_io_i = 1'b0;
    logic       dst_io_i = 1'b0;
    logic       same_bank_i = 1'b0;
    logic [7:0] result_o;
    logic       res_valid_o;
    logic       ovf_o;

    int checks = 0;
    int errors = 0;
    logic       model_ovf = 1'b0;
    logic [7:0] last_res = '0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #10 clk = ~clk;

    field_xfer_path uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i),
        .rot_i(rot_i), .len_i(len_i), .pos_i(pos_i), .op_i(op_i),
        .acc_i(acc_i), .dst_i(dst_i), .src_io_i(src_io_i),
        .dst_io_i(dst_io_i), .same_bank_i(same_bank_i),
        .result_o(result_o), .res_valid_o(res_valid_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got ovf=%0b res=%02h expected ovf=%0b res=%02h",
                     tag, got[8], got[7:0], want[8], want[7:0]);
        end
    endtask

    // Independent bit-level reference built from the requirement text
    task automatic send(input string tag, input logic [7:0] s, input int r, input int l,
                        input int p, input int o, input logic [7:0] a, input logic [7:0] d,
                        input bit sio, input bit dio, input bit sb);
        logic [7:0] opnd, y, bg, res;
        logic [8:0] wide;
        bit merge;
        for (int i = 0; i < 8; i++) begin
            opnd[i] = s[(i + r) % 8];
            if (sio && i > l) opnd[i] = 1'b0;
        end
        wide = {1'b0, opnd} + {1'b0, a};
        case (o)
            0: y = opnd;
            1: begin y = wide[7:0]; model_ovf = wide[8]; end
            2: y = opnd & a;
            default: y = opnd ^ a;
        endcase
        merge = dio && (!sio || sb);
        bg = sio ? s : d;
        for (int j = 0; j < 8; j++) begin
            if (j >= p && j <= p + l) res[j] = y[j - p];
            else if (merge) res[j] = bg[j];
            else if (j >= p) res[j] = y[j - p];
            else res[j] = 1'b0;
        end
        last_res = res;
        exp_q.push_back({model_ovf, res});
        tag_q.push_back(tag);
        valid_i = 1'b1; src_i = s; rot_i = 3'(r); len_i = 3'(l); pos_i = 3'(p);
        op_i = 2'(o); acc_i = a; dst_i = d; src_io_i = sio; dst_io_i = dio; same_bank_i = sb;
        @(posedge clk); #2;
        valid_i = 1'b0;
    endtask

    // Monitor: pop expected items as results come out
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected result", {ovf_o, result_o}, 9'h1ff);
            end else begin
                check(tag_q.pop_front(), {ovf_o, result_o}, exp_q.pop_front());
            end
        end
    end

    initial begin
        for (int n = 0; n < 200000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset state", {ovf_o, result_o}, 9'h000);
        check("R1 reset valid", {8'h00, res_valid_o}, 9'h000);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 after release", {res_valid_o, result_o}, 9'h000);

        send("R5 move reg", 8'hB4, 0, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        send("R3 rotate 3", 8'hB4, 3, 7, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        send("R3 rotate 7", 8'h81, 7, 7, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        send("R4 io mask 4 bits", 8'hDB, 1, 3, 0, 0, 8'h00, 8'h00, 1, 0, 0);
        send("R4 reg ignores len", 8'hDB, 1, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0);
        send("R6 add no carry", 8'h12, 0, 7, 0, 1, 8'h34, 8'h00, 0, 0, 0);
        send("R6 add carry", 8'hF0, 0, 7, 0, 1, 8'h20, 8'h00, 0, 0, 0);
        send("R6 and keeps ovf", 8'hF0, 0, 7, 0, 2, 8'h3C, 8'h00, 0, 0, 0);
        send("R5 xor", 8'hF0, 0, 7, 0, 3, 8'h3C, 8'h00, 0, 0, 0);
        send("R6 add clears", 8'h01, 0, 7, 0, 1, 8'h01, 8'h00, 0, 0, 0);
        send("R7 merge into dest", 8'h03, 0, 1, 2, 0, 8'h00, 8'hA5, 0, 1, 1);
        send("R8 same bank bg", 8'h9C, 2, 2, 3, 0, 8'h00, 8'h00, 1, 1, 1);
        send("R9 opposite bank", 8'h9C, 2, 2, 3, 0, 8'h00, 8'hFF, 1, 1, 0);
        send("R9 reg dest shift", 8'h5A, 0, 7, 2, 0, 8'h00, 8'hFF, 0, 0, 0);
        send("R10 clipped field", 8'h7F, 0, 6, 6, 0, 8'h00, 8'h15, 0, 1, 0);
        send("R10 clip same bank", 8'hE3, 0, 4, 5, 3, 8'hFF, 8'h00, 1, 1, 1);
        for (int k = 0; k < 300; k++) begin
            send("R2 back-to-back", 8'($urandom), $urandom % 8, $urandom % 8, $urandom % 8,
                 $urandom % 4, 8'($urandom), 8'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11 idle hold", {res_valid_o, result_o}, {1'b0, last_res});
        check("R6 idle ovf hold", {8'h00, ovf_o}, {8'h00, model_ovf});
        check("R2 queue drained", 9'(exp_q.size()), 9'h000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule